// File: doc/BRIEF.md
# PLL Lock Tracker and Core Clock Enable Selector

This block decides which core clock rate the rest of the chip sees while a phase-locked loop acquires lock. Clock selection is modelled as an enable stream in the PLL clock domain. While the loop is unlocked, the enable pulses once every eighth PLL cycle. Once lock is seen, the enable stays high on every cycle. A change of rate takes effect only at the end of an eight-cycle window, so neither direction produces a shortened enable period.

The lock indicator from the analog loop is asynchronous. It passes through a two-stage synchronizer before the block uses it. A 32-bit status word is always visible on the read port. It carries three things: the current rate as a lock flag, a sticky flag that records a drop out of full rate, and the live level of the crystal input pin. Software acknowledges the sticky flag by writing a one to it. The interrupt request is that flag gated by an enable input.

Top module: `pll_lock_clksel`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the status word reads 0x00000002 when the crystal pin is low, and the clock enable is high. The block starts in full-rate mode, its window counter is at 0 and its sticky flag is clear.
- R2: In divided mode, the clock enable is high only on the last cycle of each eight-cycle window (window counter value 7) and low on the other seven.
- R3: In full-rate mode, the clock enable is high on every cycle.
- R4: The lock input is sampled through two flip-flops. The mode register loads the synchronized lock level only at the end of a window, so the new mode shows from the cycle after a window-end cycle.
- R5: Status bit 1 reads 1 in full-rate mode and 0 in divided mode.
- R6: Status bit 0 is set in the same update that moves the mode from full rate to divided, and only then.
- R7: A write with bit 0 set clears status bit 0. If a set and a clear fall in the same cycle, the set wins.
- R8: A write with bit 0 clear has no effect on the status word, whatever the other written bits are.
- R9: Status bit 2 follows the crystal pin level combinationally, with no latching.
- R10: Status bits 31 down to 3 always read 0.
- R11: The interrupt output equals status bit 0 ANDed with the interrupt-enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL output clock; all state runs on it |
| rstN | input | 1 | Asynchronous active-low reset |
| lockRaw | input | 1 | Asynchronous lock indicator from the PLL |
| xtalPin | input | 1 | Raw level of the external crystal pin |
| busWrEn | input | 1 | Write strobe for the status word |
| busWrData | input | 32 | Write data; only bit 0 has an effect |
| busRdData | output | 32 | Status word: bit 2 crystal level, bit 1 lock flag, bit 0 sticky loss flag |
| irqEn | input | 1 | Interrupt enable |
| coreClkEn | output | 1 | Selected core clock enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are the ones where the timing of the lock input meets the eight-cycle window. These are a drop that lands on each of the eight window phases, a lock pulse only one cycle long that is either caught or missed by a window end, and an acknowledge write that lands on the very cycle the flag is set. The stimulus sweeps the drop position through all eight phase offsets and issues one-cycle lock glitches. It also holds a clearing write across a drop. A behavioural model tracks the window phase, the synchronizer delay and the flag on every clock and is compared with every output.

// File: rtl/pll_lock_clksel_pkg.sv
package pll_lock_clksel_pkg;
  localparam int STATUS_W = 32;
  localparam int IRQ_BIT  = 0;
  localparam int LOCK_BIT = 1;
  localparam int XTAL_BIT = 2;

  typedef struct packed {
    logic goFull;
    logic goDiv;
    logic setIrq;
    logic clrIrq;
  } ctrlStrobe_t;
endpackage

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
  import pll_lock_clksel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lockRaw,
  input  logic        windowEnd,
  input  logic        fullMode,
  input  logic        wrEn,
  input  logic        wrIrqBit,
  output ctrlStrobe_t strobes
);
  logic [SYNC_STAGES-1:0] syncReg;
  logic                   lockSynced;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncReg[g] <= 1'b1;
          else       syncReg[g] <= lockRaw;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncReg[g] <= 1'b1;
          else       syncReg[g] <= syncReg[g-1];
        end
      end
    end
  endgenerate

  assign lockSynced = syncReg[SYNC_STAGES-1];

  always_comb begin
    strobes.goFull = windowEnd && !fullMode && lockSynced;
    strobes.goDiv  = windowEnd && fullMode && !lockSynced;
    strobes.setIrq = strobes.goDiv;
    strobes.clrIrq = wrEn && wrIrqBit;
  end
endmodule

// File: rtl/pll_lock_datapath.sv
module pll_lock_datapath
  import pll_lock_clksel_pkg::*;
#(
  parameter int DIV_LOG2 = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobes,
  input  logic                xtalPin,
  output logic                windowEnd,
  output logic                fullMode,
  output logic                coreClkEn,
  output logic [STATUS_W-1:0] statusWord
);
  localparam logic [DIV_LOG2-1:0] LAST_PHASE = {DIV_LOG2{1'b1}};

  logic [DIV_LOG2-1:0] phaseCnt;
  logic                irqFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseCnt <= '0;
    else       phaseCnt <= phaseCnt + 1'b1;
  end

  assign windowEnd = (phaseCnt == LAST_PHASE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              fullMode <= 1'b1;
    else if (strobes.goFull) fullMode <= 1'b1;
    else if (strobes.goDiv)  fullMode <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               irqFlag <= 1'b0;
    else if (strobes.setIrq) irqFlag <= 1'b1;
    else if (strobes.clrIrq) irqFlag <= 1'b0;
  end

  assign coreClkEn = fullMode || windowEnd;

  always_comb begin
    statusWord           = '0;
    statusWord[IRQ_BIT]  = irqFlag;
    statusWord[LOCK_BIT] = fullMode;
    statusWord[XTAL_BIT] = xtalPin;
  end
endmodule

// File: rtl/pll_lock_clksel.sv
module pll_lock_clksel
  import pll_lock_clksel_pkg::*;
#(
  parameter int DIV_LOG2    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lockRaw,
  input  logic                xtalPin,
  input  logic                busWrEn,
  input  logic [STATUS_W-1:0] busWrData,
  output logic [STATUS_W-1:0] busRdData,
  input  logic                irqEn,
  output logic                coreClkEn,
  output logic                irq
);
  ctrlStrobe_t strobes;
  logic        windowEnd;
  logic        fullMode;

  pll_lock_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .lockRaw   (lockRaw),
    .windowEnd (windowEnd),
    .fullMode  (fullMode),
    .wrEn      (busWrEn),
    .wrIrqBit  (busWrData[IRQ_BIT]),
    .strobes   (strobes)
  );

  pll_lock_datapath #(.DIV_LOG2(DIV_LOG2)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .xtalPin    (xtalPin),
    .windowEnd  (windowEnd),
    .fullMode   (fullMode),
    .coreClkEn  (coreClkEn),
    .statusWord (busRdData)
  );

  assign irq = busRdData[IRQ_BIT] && irqEn;
endmodule

// File: rtl/pll_lock_clksel_chk.sv
module pll_lock_clksel_chk (
  input logic        clk,
  input logic        rstN,
  input logic        xtalPin,
  input logic        busWrEn,
  input logic [31:0] busWrData,
  input logic [31:0] busRdData,
  input logic        irqEn,
  input logic        coreClkEn,
  input logic        irq
);
  // R2
  div_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdData[1] && coreClkEn) |=> (!coreClkEn || busRdData[1]));

  // R3
  full_rate_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[1] |-> coreClkEn);

  // R4
  switch_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(busRdData[1]) |-> $past(coreClkEn));

  // R6
  loss_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busRdData[1]) |-> busRdData[0]);

  // R8
  zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !busWrData[0] && busRdData[0]) |=> busRdData[0]);

  // R9
  xtal_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[2] == xtalPin);

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[31:3] == '0);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq == (busRdData[0] && irqEn));
endmodule

bind pll_lock_clksel pll_lock_clksel_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .xtalPin   (xtalPin),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .irqEn     (irqEn),
  .coreClkEn (coreClkEn),
  .irq       (irq)
);

// File: tb/test_pll_lock_clksel.sv
`timescale 1ns/1ps
module test_pll_lock_clksel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lockRaw = 1'b1;
  logic        xtalPin = 1'b0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqEn = 1'b0;
  logic        coreClkEn;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  int mA = 1, mB = 1, mPhase = 0, mFull = 1, mIrq = 0;

  always #2 clk = ~clk;

  pll_lock_clksel i_pll_lock_clksel (
    .clk(clk), .rstN(rstN), .lockRaw(lockRaw), .xtalPin(xtalPin),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqEn(irqEn), .coreClkEn(coreClkEn), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    int oldB, oldFull, oldPhase;
    cycles++;
    if (!rstN) begin
      mA = 1; mB = 1; mPhase = 0; mFull = 1; mIrq = 0;
    end else begin
      oldB = mB; oldFull = mFull; oldPhase = mPhase;
      mB = mA;
      mA = int'(lockRaw);
      mPhase = (mPhase + 1) % 8;
      if (oldPhase == 7) mFull = oldB;
      if (oldFull == 1 && oldPhase == 7 && oldB == 0) mIrq = 1;
      else if (busWrEn && busWrData[0]) mIrq = 0;
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      int expEn;
      expEn = (mFull == 1 || mPhase == 7) ? 1 : 0;
      check(int'(coreClkEn) == expEn, "R2 R3 R4 enable", int'(coreClkEn), expEn);
      check(int'(busRdData[1]) == mFull, "R5 lock flag", int'(busRdData[1]), mFull);
      check(int'(busRdData[0]) == mIrq, "R6 R7 R8 sticky flag", int'(busRdData[0]), mIrq);
      check(busRdData[2] == xtalPin, "R9 crystal bit", int'(busRdData[2]), int'(xtalPin));
      check(busRdData[31:3] == '0, "R10 reserved bits", int'(busRdData[31:3]), 0);
      check(int'(irq) == (mIrq & int'(irqEn)), "R11 irq", int'(irq), mIrq & int'(irqEn));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      xtalPin = ~xtalPin;
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(posedge clk); #1;
    busWrEn = 1'b1; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0; busWrData = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state seen at the ports
    check(busRdData == 32'h2, "R1 reset status", int'(busRdData), 2);
    check(coreClkEn == 1'b1, "R1 reset enable", int'(coreClkEn), 1);
    rstN = 1'b1;
    #1;
    check(busRdData == 32'h2, "R1 status after release", int'(busRdData), 2);
    step(12);
    irqEn = 1'b1;
    lockRaw = 1'b0;
    step(30);
    wr(32'hFFFF_FFFE);          // R8: bit 0 clear, flag must stay
    step(3);
    wr(32'h0);                  // R8
    step(3);
    irqEn = 1'b0;               // R11 gating
    step(4);
    irqEn = 1'b1;
    wr(32'h1);                  // R7 clear
    step(5);
    lockRaw = 1'b1;
    step(25);
    // R4 R6: drop at every window phase offset
    for (int k = 0; k < 8; k++) begin
      step(k + 1);
      lockRaw = 1'b0;
      step(20);
      wr(32'h1);
      lockRaw = 1'b1;
      step(20 + k);
    end
    // one-cycle lock glitches at different offsets
    for (int k = 0; k < 10; k++) begin
      step(k + 3);
      lockRaw = 1'b0;
      step(1);
      lockRaw = 1'b1;
      step(12);
      wr(32'h1);
    end
    // R7: clearing write held across a drop, set wins on the collision cycle
    @(posedge clk); #1;
    busWrEn = 1'b1; busWrData = 32'h1;
    lockRaw = 1'b0;
    step(20);
    busWrEn = 1'b0; busWrData = '0;
    step(4);
    lockRaw = 1'b1;
    step(20);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule